// File: doc/BRIEF.md
# Sample Ring Buffer with Interrupt Flags

This block stores conversion results from an acquisition engine in a circular buffer whose depth is not a power of two (2003 words of 16 bits by default). The producer presents one sample per cycle. Each accepted sample goes into the slot named by the front index, and the front index then advances. The host fetches any slot by index through a registered read port. It returns slots to the producer by writing a new rear index. Both indices wrap to zero by comparison against the depth, not by bit truncation.

An eight-bit flag register collects interrupt causes. The buffer itself drives three of them: the fill level has reached a programmable threshold, the producer overran a full ring, or the host wrote an invalid rear index. Five more flags are set by event inputs from neighbouring logic. The host clears flags by writing ones, and an eight-bit mask selects which flags drive the single interrupt line.

Top module: `samp_ring_irq`

## Requirements
- R1: After reset, front index, rear index and fill count are 0, the flag and mask registers are 0, the interrupt is low, and the fill threshold is 1001.
- R2: A producer write with the ring not full stores `prod_data` at the front index, and the front index advances by one on the next edge. It wraps from DEPTH-1 to 0.
- R3: `fill_count` equals front minus rear, with DEPTH added when that difference is negative.
- R4: A valid host write of `rear_wdata` takes effect on the next edge. It is valid when the value is below DEPTH and releases no more entries than are occupied. The rear index wraps like the front index.
- R5: `rd_data` shows the word at `rd_idx` one edge after `rd_en` and holds that value while `rd_en` is low. An index of DEPTH or more returns 0.
- R6: A producer write while the ring holds DEPTH-1 entries is dropped. The front index stays where it is and flag bit 2 (hardware overrun) is set.
- R7: An invalid rear write is ignored, leaving the rear index unchanged, and sets flag bit 1 (software overrun).
- R8: Flag bit 0 is set on the edge after any cycle in which the fill count is at or above the threshold. `thresh_wr` loads a new threshold.
- R9: Each bit n of `evt_set` sets flag bit n+3 on the next edge. The bits are, from bit 3 to bit 7: output empty, output software error, output hardware error, counter done, command done.
- R10: `flag_clr_wr` clears every flag bit that is 1 in `flag_clr_wdata`. A flag set by a cause in the same cycle stays set.
- R11: `irq` is high exactly when some flag bit and the same mask bit are both 1. Writing a mask of 0 drives `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prod_valid | input | 1 | Producer writes a sample this cycle |
| prod_data | input | 16 | Sample value |
| front_idx | output | 11 | Next slot the producer fills |
| rear_wr | input | 1 | Host writes the rear index |
| rear_wdata | input | 11 | New rear index |
| rear_idx | output | 11 | Oldest unreleased slot |
| fill_count | output | 11 | Occupied entries |
| rd_en | input | 1 | Host read strobe |
| rd_idx | input | 11 | Slot to read |
| rd_data | output | 16 | Read word, one cycle after the strobe |
| thresh_wr | input | 1 | Load the fill threshold |
| thresh_wdata | input | 11 | New threshold |
| mask_wr | input | 1 | Load the interrupt mask |
| mask_wdata | input | 8 | New mask |
| flag_clr_wr | input | 1 | Write-one-to-clear strobe |
| flag_clr_wdata | input | 8 | Flag bits to clear |
| evt_set | input | 5 | External causes for flag bits 3 to 7 |
| flags | output | 8 | Flag register |
| mask | output | 8 | Mask register |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions matter most. The first is a producer write on a full ring in the same cycle as a host clear of the overrun flag; the flag must stay set and the sample must be dropped. The second is a producer write in the same cycle as a rear release; both must be judged against the occupancy at the start of that cycle. The bench drives each pair of strobes in one cycle. A behavioural model advances each cycle from the same inputs, and every output is compared against that model on each clock. Named checks confirm the expected flag, index and count at the cycle after each collision.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;
  localparam int FLAG_W    = 8;
  localparam int EVT_W     = 5;
  localparam int F_THRESH  = 0;
  localparam int F_SW_OVR  = 1;
  localparam int F_HW_OVR  = 2;
  localparam int F_EVT_LO  = 3;

  // distance walked forward from lo to hi on a ring of the given depth
  function automatic logic [31:0] ring_span(input logic [31:0] hi,
                                            input logic [31:0] lo,
                                            input logic [31:0] depth);
    if (hi >= lo) return hi - lo;
    return hi + depth - lo;
  endfunction
endpackage

// File: rtl/rbuf_store.sv
module rbuf_store #(
  parameter int DEPTH = 2003,
  parameter int DW    = 16,
  parameter int IDXW  = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] waddr,
  input  logic [DW-1:0]   wdata,
  input  logic            re,
  input  logic [IDXW-1:0] raddr,
  output logic [DW-1:0]   rdata
);
  localparam logic [IDXW-1:0] DEPTH_L = IDXW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q, rdata_d;

  // storage array: write enabled, no reset
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (re) begin
      if (raddr < DEPTH_L) rdata_d = mem[raddr];
      else                 rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // R5
  rd_oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (re && raddr >= DEPTH_L) |=> (rdata == '0));

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!re) |=> $stable(rdata));
endmodule

// File: rtl/rbuf_index.sv
module rbuf_index
  import rbuf_pkg::*;
#(
  parameter int DEPTH = 2003,
  parameter int IDXW  = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prod_valid,
  input  logic            rear_wr,
  input  logic [IDXW-1:0] rear_wdata,
  output logic [IDXW-1:0] front_q,
  output logic [IDXW-1:0] rear_q,
  output logic [IDXW-1:0] count,
  output logic            mem_we,
  output logic            hw_ovr,
  output logic            sw_ovr
);
  localparam logic [IDXW-1:0] DEPTH_L = IDXW'(DEPTH);
  localparam logic [IDXW-1:0] LAST_L  = IDXW'(DEPTH - 1);

  logic [IDXW-1:0] front_d, rear_d, release_n;
  logic            ring_full, rear_ok;

  always_comb begin
    count     = ring_span(32'(front_q), 32'(rear_q), 32'(DEPTH))
                [IDXW-1:0];
    release_n = ring_span(32'(rear_wdata), 32'(rear_q), 32'(DEPTH))
                [IDXW-1:0];
    ring_full = (count == LAST_L);
    rear_ok   = (rear_wdata < DEPTH_L) && (release_n <= count);
    mem_we    = prod_valid && !ring_full;
    hw_ovr    = prod_valid && ring_full;
    sw_ovr    = rear_wr && !rear_ok;
  end

  always_comb begin
    front_d = front_q;
    rear_d  = rear_q;
    if (mem_we) begin
      if (front_q == LAST_L) front_d = '0;
      else                   front_d = front_q + IDXW'(1);
    end
    if (rear_wr && rear_ok) rear_d = rear_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      front_q <= '0;
      rear_q  <= '0;
    end else begin
      front_q <= front_d;
      rear_q  <= rear_d;
    end
  end

  // R2
  front_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    front_q < DEPTH_L);

  // R4
  rear_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rear_q < DEPTH_L);

  // R6
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_valid && count == LAST_L) |=> (front_q == $past(front_q)));

  // R7
  bad_rear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rear_wr && rear_wdata >= DEPTH_L) |=> (rear_q == $past(rear_q)));

  // R3
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LAST_L);
endmodule

// File: rtl/rbuf_irq.sv
module rbuf_irq
  import rbuf_pkg::*;
#(
  parameter int DEPTH = 2003,
  parameter int IDXW  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDXW-1:0]   count,
  input  logic              hw_ovr,
  input  logic              sw_ovr,
  input  logic [EVT_W-1:0]  evt_set,
  input  logic              thresh_wr,
  input  logic [IDXW-1:0]   thresh_wdata,
  input  logic              mask_wr,
  input  logic [FLAG_W-1:0] mask_wdata,
  input  logic              clr_wr,
  input  logic [FLAG_W-1:0] clr_wdata,
  output logic [FLAG_W-1:0] flags_q,
  output logic [FLAG_W-1:0] mask_q,
  output logic              irq_o
);
  localparam logic [IDXW-1:0] THRESH_RST = IDXW'(DEPTH / 2);

  logic [IDXW-1:0]   thresh_q, thresh_d;
  logic [FLAG_W-1:0] set_vec, clr_vec, flags_d, mask_d;

  always_comb begin
    set_vec = '0;
    set_vec[F_THRESH] = (count >= thresh_q);
    set_vec[F_SW_OVR] = sw_ovr;
    set_vec[F_HW_OVR] = hw_ovr;
    for (int i = 0; i < EVT_W; i++) set_vec[F_EVT_LO + i] = evt_set[i];
    clr_vec  = clr_wr ? clr_wdata : '0;
    flags_d  = (flags_q & ~clr_vec) | set_vec;
    mask_d   = mask_wr ? mask_wdata : mask_q;
    thresh_d = thresh_wr ? thresh_wdata : thresh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q  <= '0;
      mask_q   <= '0;
      thresh_q <= THRESH_RST;
    end else begin
      flags_q  <= flags_d;
      mask_q   <= mask_d;
      thresh_q <= thresh_d;
    end
  end

  assign irq_o = |(flags_q & mask_q);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

  // R8
  thr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= thresh_q) |=> flags_q[F_THRESH]);

  // R11
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && mask_wdata == '0) |=> !irq_o);

  // R9
  evt_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_set[EVT_W-1] |=> flags_q[FLAG_W-1]);
endmodule

// File: rtl/samp_ring_irq.sv
module samp_ring_irq
  import rbuf_pkg::*;
#(
  parameter int DEPTH = 2003,
  parameter int DW    = 16,
  localparam int IDXW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prod_valid,
  input  logic [DW-1:0]     prod_data,
  output logic [IDXW-1:0]   front_idx,
  input  logic              rear_wr,
  input  logic [IDXW-1:0]   rear_wdata,
  output logic [IDXW-1:0]   rear_idx,
  output logic [IDXW-1:0]   fill_count,
  input  logic              rd_en,
  input  logic [IDXW-1:0]   rd_idx,
  output logic [DW-1:0]     rd_data,
  input  logic              thresh_wr,
  input  logic [IDXW-1:0]   thresh_wdata,
  input  logic              mask_wr,
  input  logic [FLAG_W-1:0] mask_wdata,
  input  logic              flag_clr_wr,
  input  logic [FLAG_W-1:0] flag_clr_wdata,
  input  logic [EVT_W-1:0]  evt_set,
  output logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] mask,
  output logic              irq
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       mem_we, hw_ovr, sw_ovr;

  // assert asynchronously, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  rbuf_index #(.DEPTH(DEPTH), .IDXW(IDXW)) u_index (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .prod_valid (prod_valid),
    .rear_wr    (rear_wr),
    .rear_wdata (rear_wdata),
    .front_q    (front_idx),
    .rear_q     (rear_idx),
    .count      (fill_count),
    .mem_we     (mem_we),
    .hw_ovr     (hw_ovr),
    .sw_ovr     (sw_ovr)
  );

  rbuf_store #(.DEPTH(DEPTH), .DW(DW), .IDXW(IDXW)) u_store (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (mem_we),
    .waddr (front_idx),
    .wdata (prod_data),
    .re    (rd_en),
    .raddr (rd_idx),
    .rdata (rd_data)
  );

  rbuf_irq #(.DEPTH(DEPTH), .IDXW(IDXW)) u_irq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .count        (fill_count),
    .hw_ovr       (hw_ovr),
    .sw_ovr       (sw_ovr),
    .evt_set      (evt_set),
    .thresh_wr    (thresh_wr),
    .thresh_wdata (thresh_wdata),
    .mask_wr      (mask_wr),
    .mask_wdata   (mask_wdata),
    .clr_wr       (flag_clr_wr),
    .clr_wdata    (flag_clr_wdata),
    .flags_q      (flags),
    .mask_q       (mask),
    .irq_o        (irq)
  );

  // R6
  ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    hw_ovr |=> flags[F_HW_OVR]);
endmodule

// File: tb/samp_ring_irq_tb.sv
module samp_ring_irq_tb;
  localparam int D  = 2003;
  localparam int DW = 16;
  localparam int IW = 11;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          prod_valid;
  logic [DW-1:0] prod_data;
  logic [IW-1:0] front_idx, rear_idx, fill_count;
  logic          rear_wr;
  logic [IW-1:0] rear_wdata;
  logic          rd_en;
  logic [IW-1:0] rd_idx;
  logic [DW-1:0] rd_data;
  logic          thresh_wr;
  logic [IW-1:0] thresh_wdata;
  logic          mask_wr;
  logic [7:0]    mask_wdata;
  logic          flag_clr_wr;
  logic [7:0]    flag_clr_wdata;
  logic [4:0]    evt_set;
  logic [7:0]    flags, mask;
  logic          irq;

  samp_ring_irq #(.DEPTH(D), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .prod_valid(prod_valid), .prod_data(prod_data),
    .front_idx(front_idx), .rear_wr(rear_wr), .rear_wdata(rear_wdata),
    .rear_idx(rear_idx), .fill_count(fill_count), .rd_en(rd_en),
    .rd_idx(rd_idx), .rd_data(rd_data), .thresh_wr(thresh_wr),
    .thresh_wdata(thresh_wdata), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .flag_clr_wr(flag_clr_wr), .flag_clr_wdata(flag_clr_wdata),
    .evt_set(evt_set), .flags(flags), .mask(mask), .irq(irq)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int m_front = 0, m_rear = 0, m_thr = 1001, m_mask = 0, m_flags = 0, m_rd = 0;
  int m_mem [D];
  int saved;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int m_cnt();
    return (m_front >= m_rear) ? m_front - m_rear : m_front + D - m_rear;
  endfunction

  function automatic int pat(input int i);
    return (i * 37 + 5) & 16'hFFFF;
  endfunction

  task automatic idle_inputs();
    prod_valid = 0; rear_wr = 0; rd_en = 0; thresh_wr = 0;
    mask_wr = 0; flag_clr_wr = 0; evt_set = '0;
  endtask

  // one clock: update the model from the driven inputs, then compare
  task automatic cycle();
    int c, setv, rel, clr;
    c = m_cnt();
    setv = 0;
    if (rd_en) m_rd = (int'(rd_idx) < D) ? m_mem[rd_idx] : 0;
    if (prod_valid) begin
      if (c == D - 1) setv |= 4;
      else begin
        m_mem[m_front] = int'(prod_data);
        m_front = (m_front == D - 1) ? 0 : m_front + 1;
      end
    end
    if (rear_wr) begin
      if (int'(rear_wdata) >= D) setv |= 2;
      else begin
        rel = (int'(rear_wdata) >= m_rear) ? int'(rear_wdata) - m_rear
                                           : int'(rear_wdata) + D - m_rear;
        if (rel > c) setv |= 2;
        else m_rear = int'(rear_wdata);
      end
    end
    if (c >= m_thr) setv |= 1;
    setv |= int'(evt_set) << 3;
    clr = flag_clr_wr ? int'(flag_clr_wdata) : 0;
    m_flags = ((m_flags & ~clr) | setv) & 255;
    if (mask_wr) m_mask = int'(mask_wdata);
    if (thresh_wr) m_thr = int'(thresh_wdata);
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    chk("R2 front_idx", int'(front_idx), m_front);
    chk("R4 rear_idx", int'(rear_idx), m_rear);
    chk("R3 fill_count", int'(fill_count), m_cnt());
    chk("R10 flags", int'(flags), m_flags);
    chk("R11 mask", int'(mask), m_mask);
    chk("R11 irq", int'(irq), ((m_flags & m_mask) != 0) ? 1 : 0);
    chk("R5 rd_data", int'(rd_data), m_rd);
  endtask

  task automatic produce(input int v);
    prod_valid = 1; prod_data = DW'(v);
    cycle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; prod_data = '0; rear_wdata = '0; rd_idx = '0;
    thresh_wdata = '0; mask_wdata = '0; flag_clr_wdata = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 front", int'(front_idx), 0);
    chk("R1 rear", int'(rear_idx), 0);
    chk("R1 count", int'(fill_count), 0);
    chk("R1 flags", int'(flags), 0);
    chk("R1 mask", int'(mask), 0);
    chk("R1 irq", int'(irq), 0);
    rst_n = 1;
    repeat (4) cycle();

    mask_wr = 1; mask_wdata = 8'hFF; cycle();

    // fill to just below then at the default threshold
    for (int i = 0; i < 1001; i++) produce(pat(i));
    chk("R1 threshold not yet hit at 1000", int'(flags[0]), 0);
    cycle();
    chk("R1 default threshold 1001 sets bit0", int'(flags[0]), 1);
    chk("R8 threshold flag", int'(flags[0]), 1);
    chk("R11 irq with mask", int'(irq), 1);

    // reads, including an out-of-range index
    rd_en = 1; rd_idx = 11'd0; cycle();
    chk("R5 read slot 0", int'(rd_data), pat(0));
    rd_en = 1; rd_idx = 11'd1000; cycle();
    chk("R5 read slot 1000", int'(rd_data), pat(1000));
    cycle();
    chk("R5 read data held", int'(rd_data), pat(1000));
    rd_en = 1; rd_idx = 11'd2010; cycle();
    chk("R5 read out of range", int'(rd_data), 0);

    // clear while the cause persists: set wins
    flag_clr_wr = 1; flag_clr_wdata = 8'h01; cycle();
    chk("R10 set wins over clear", int'(flags[0]), 1);
    rear_wr = 1; rear_wdata = 11'd600; cycle();
    chk("R4 rear accepted", int'(rear_idx), 600);
    flag_clr_wr = 1; flag_clr_wdata = 8'h01; cycle();
    chk("R10 cleared below threshold", int'(flags[0]), 0);
    chk("R3 count after release", int'(fill_count), 401);

    // invalid rear writes
    rear_wr = 1; rear_wdata = 11'd1500; cycle();
    chk("R7 over-release ignored", int'(rear_idx), 600);
    chk("R7 sw flag", int'(flags[1]), 1);
    flag_clr_wr = 1; flag_clr_wdata = 8'h02; cycle();
    rear_wr = 1; rear_wdata = 11'd2005; cycle();
    chk("R7 out-of-range ignored", int'(rear_idx), 600);
    chk("R7 sw flag again", int'(flags[1]), 1);
    flag_clr_wr = 1; flag_clr_wdata = 8'hFF; cycle();

    // programmable threshold
    thresh_wr = 1; thresh_wdata = 11'd405; cycle();
    for (int i = 0; i < 4; i++) produce(pat(2000 + i));
    chk("R8 below new threshold", int'(flags[0]), 0);
    cycle();
    chk("R8 new threshold 405 hit", int'(flags[0]), 1);

    // fill the ring, then overrun while clearing the overrun flag
    while (m_cnt() < D - 1) produce(pat(m_front));
    chk("R6 count full", int'(fill_count), D - 1);
    saved = int'(front_idx);
    prod_valid = 1; prod_data = 16'hDEAD;
    flag_clr_wr = 1; flag_clr_wdata = 8'h04; cycle();
    chk("R6 overrun flag despite clear", int'(flags[2]), 1);
    chk("R6 front unchanged", int'(front_idx), saved);
    chk("R6 sample dropped count", int'(fill_count), D - 1);

    // producer and release in one cycle: producer judged on old count
    prod_valid = 1; prod_data = 16'hBEEF;
    rear_wr = 1; rear_wdata = 11'((int'(rear_idx) + 10) % D); cycle();
    chk("R6 write on full dropped with release", int'(fill_count), D - 11);
    chk("R4 release in same cycle", int'(front_idx), saved);

    // empty and wrap the front index
    rear_wr = 1; rear_wdata = front_idx; cycle();
    chk("R4 ring empty", int'(fill_count), 0);
    while (m_front != 0) produce(pat(m_front + 7));
    chk("R2 front wrapped to 0", int'(front_idx), 0);
    rd_en = 1; rd_idx = 11'(D - 1); cycle();
    chk("R2 last slot written", int'(rd_data), pat(D - 1 + 7));
    produce(16'h1234);
    chk("R3 count across wrap", int'(fill_count), D - saved + 1);
    rear_wr = 1; rear_wdata = 11'd1; cycle();
    chk("R4 rear wrapped", int'(rear_idx), 1);

    // event inputs and masking
    flag_clr_wr = 1; flag_clr_wdata = 8'hFF;
    mask_wr = 1; mask_wdata = 8'h00; cycle();
    evt_set = 5'b10101; cycle();
    chk("R9 event flags", int'(flags[7:3]), 5'b10101);
    chk("R11 masked off", int'(irq), 0);
    mask_wr = 1; mask_wdata = 8'h40; cycle();
    chk("R11 mask misses set flags", int'(irq), 0);
    mask_wr = 1; mask_wdata = 8'h80; cycle();
    chk("R11 mask hits bit7", int'(irq), 1);
    evt_set = 5'b01010; flag_clr_wr = 1; flag_clr_wdata = 8'hF8; cycle();
    chk("R9 second event pattern", int'(flags[7:3]), 5'b01010);
    repeat (3) cycle();

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule